// File: doc/BRIEF.md
# Cascadable Fracturable Lookup-Table Slice

The block is one logic slice with eight configurable 6-input lookup tables, numbered 0 to 7 (positions A to H). Each table holds 64 truth bits. It can act as one 6-input function, or it can split into two 5-input functions. Each half of a table has its own fifth-input multiplexer. That multiplexer picks one of three signals:

- the table's own fifth input pin;
- the 6-input result of the previous table;
- a constant high.

Because each half picks its own fifth input, the two split functions can use six distinct inputs between them.

The cascade runs in one direction only, from position 0 up to position 7, and never leaves the slice. Hops that leave an odd-position table pass through a carry cell. On those hops the carry cell's internal propagate signal is forced so that the cell acts as a plain route-through.

All truth tables and multiplexer selects are loaded through a serial configuration chain. The chain shifts one bit per clock while the enable is high. Once configured, the datapath is purely combinational. Outputs are only defined while the enable is low.

Top module: `lut_slice`

## Requirements
- R1: While reset is asserted, and after reset with no configuration, every truth bit is 0 and every select is 00, so all 24 outputs are 0 for any inputs.
- R2: The configuration chain holds 68 bits per table and takes tables 0 to 7 in order. The first bit shifted in becomes bit 0 of table 0. Within a table, bits [31:0] are the lower truth half and bits [63:32] are the upper truth half. Bits [65:64] are the lower-half select and bits [67:66] are the upper-half select. Each bit shifts in on a rising clock edge while cfg_en_i is 1.
- R3: o6_o[i] equals the upper-half result when input A6 of table i is 1, and the lower-half result when it is 0.
- R4: o5_1_o[i] is lower-half truth bit {m_lo, A4, A3, A2, A1}, and o5_2_o[i] is upper-half truth bit {m_hi, A4, A3, A2, A1}. Here m_lo and m_hi are the outputs of that half's fifth-input multiplexer.
- R5: Select 00 passes the table's A5 pin to the multiplexer output. The reserved select 11 behaves exactly like 00.
- R6: Select 10 drives the multiplexer output to constant 1.
- R7: Select 01 passes o6_o[i-1] to the multiplexer output. For table 0, select 01 yields constant 1.
- R8: The cascade runs only upward: inputs of table j never affect the outputs of any table below j. The o6 output of table 7 feeds nothing else.
- R9: The two halves of one table can take different fifth inputs (for example cascade and pin), giving two independent 5-input results from six distinct inputs.
- R10: While cfg_en_i is 0, the configuration is retained, and toggling cfg_data_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the configuration |
| cfg_en_i | input | 1 | Shift enable of the configuration chain |
| cfg_data_i | input | 1 | Serial configuration data |
| lut_in_i | input | 48 | Table inputs; bits [6i+5:6i] are A6..A1 of table i (A1 in bit 6i) |
| o6_o | output | 8 | 6-input result per table |
| o5_1_o | output | 8 | Lower 5-input result per table |
| o5_2_o | output | 8 | Upper 5-input result per table |

## Verification
Within one table, the cascade and the pin can feed the two halves in the same evaluation. One half then follows the ripple from the tables below, while the other follows the local A5 pin. The bench provokes this by setting the previous table's result and the local A5 pin to opposite values. It then judges whether o5_1 and o5_2 of that table split accordingly. A ripple through all eight positions is also run, and the whole output vector is compared against hand-derived values. The two directed cases force the ripple to stop at a chosen table and to skip past the top position.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
  localparam int unsigned LUT_K   = 6;
  localparam int unsigned TT_W    = 1 << LUT_K;
  localparam int unsigned HALF_W  = TT_W / 2;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned FIELD_W = TT_W + 2 * SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_PIN  = 2'b00,
    SEL_CASC = 2'b01,
    SEL_HIGH = 2'b10,
    SEL_RSVD = 2'b11
  } fifth_sel_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel_hi;
    logic [SEL_W-1:0] sel_lo;
    logic [TT_W-1:0]  tt;
  } lut_cfg_t;
endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
  parameter int unsigned CHAIN_W = 544
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_en_i,
  input  logic               data_i,
  output logic [CHAIN_W-1:0] chain_o
);
  logic [CHAIN_W-1:0] chain_q;

  // first bit entered travels down to bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else if (shift_en_i) chain_q <= {data_i, chain_q[CHAIN_W-1:1]};
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/fifth_mux.sv
module fifth_mux
  import lut_slice_pkg::*;
#(
  parameter bit HAS_SRC = 1'b1
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pin_i,
  input  logic             casc_i,
  output logic             out_o
);
  always_comb begin
    unique case (fifth_sel_e'(sel_i))
      SEL_CASC: out_o = HAS_SRC ? casc_i : 1'b1;
      SEL_HIGH: out_o = 1'b1;
      default:  out_o = pin_i;
    endcase
  end
endmodule

// File: rtl/carry_route.sv
module carry_route (
  input  logic prop_i,
  input  logic ci_i,
  input  logic di_i,
  output logic co_o
);
  // propagate high: carry-in routes straight through
  assign co_o = prop_i ? ci_i : di_i;
endmodule

// File: rtl/lut6_frac.sv
module lut6_frac
  import lut_slice_pkg::*;
#(
  parameter bit HAS_CASC = 1'b1
) (
  input  lut_cfg_t         cfg_i,
  input  logic [LUT_K-1:0] in_i,
  input  logic             casc_i,
  output logic             o6_o,
  output logic             o5_1_o,
  output logic             o5_2_o
);
  localparam int unsigned IDX_W = LUT_K - 1;

  logic             m_lo, m_hi;
  logic [IDX_W-1:0] idx_lo, idx_hi;
  logic [HALF_W-1:0] tt_lo, tt_hi;

  fifth_mux #(.HAS_SRC(HAS_CASC)) u_mux_lo (
    .sel_i (cfg_i.sel_lo),
    .pin_i (in_i[4]),
    .casc_i(casc_i),
    .out_o (m_lo)
  );

  fifth_mux #(.HAS_SRC(HAS_CASC)) u_mux_hi (
    .sel_i (cfg_i.sel_hi),
    .pin_i (in_i[4]),
    .casc_i(casc_i),
    .out_o (m_hi)
  );

  assign tt_lo  = cfg_i.tt[HALF_W-1:0];
  assign tt_hi  = cfg_i.tt[TT_W-1:HALF_W];
  assign idx_lo = {m_lo, in_i[3:0]};
  assign idx_hi = {m_hi, in_i[3:0]};

  assign o5_1_o = tt_lo[idx_lo];
  assign o5_2_o = tt_hi[idx_hi];
  assign o6_o   = in_i[5] ? o5_2_o : o5_1_o;
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import lut_slice_pkg::*;
#(
  parameter int unsigned NUM_LUTS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_en_i,
  input  logic                      cfg_data_i,
  input  logic [NUM_LUTS*LUT_K-1:0] lut_in_i,
  output logic [NUM_LUTS-1:0]       o6_o,
  output logic [NUM_LUTS-1:0]       o5_1_o,
  output logic [NUM_LUTS-1:0]       o5_2_o
);
  localparam int unsigned CHAIN_W = NUM_LUTS * FIELD_W;

  logic [CHAIN_W-1:0]  cfg_chain;
  logic [NUM_LUTS-1:0] casc_in;
  logic [NUM_LUTS-1:0] prop;

  lut_cfg_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(cfg_en_i),
    .data_i    (cfg_data_i),
    .chain_o   (cfg_chain)
  );

  for (genvar i = 0; i < NUM_LUTS; i++) begin : g_lut
    lut_cfg_t cfg;
    assign cfg = lut_cfg_t'(cfg_chain[i*FIELD_W +: FIELD_W]);

    if (i == 0) begin : g_head
      assign casc_in[i] = 1'b0;
      assign prop[i]    = 1'b0;
    end else if ((i - 1) % 2 == 1) begin : g_carry_hop
      // cascade mode: propagate forced, carry cell routes O6 through
      assign prop[i] = 1'b1;
      carry_route u_route (
        .prop_i(prop[i]),
        .ci_i  (o6_o[i-1]),
        .di_i  (1'b0),
        .co_o  (casc_in[i])
      );
    end else begin : g_direct_hop
      assign casc_in[i] = o6_o[i-1];
      assign prop[i]    = 1'b0;
    end

    lut6_frac #(.HAS_CASC(i != 0)) u_lut (
      .cfg_i (cfg),
      .in_i  (lut_in_i[i*LUT_K +: LUT_K]),
      .casc_i(casc_in[i]),
      .o6_o  (o6_o[i]),
      .o5_1_o(o5_1_o[i]),
      .o5_2_o(o5_2_o[i])
    );
  end
endmodule

// File: rtl/lut_slice_checker.sv
module lut_slice_checker
  import lut_slice_pkg::*;
#(
  parameter int unsigned NUM_LUTS = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          cfg_en_i,
  input logic                          cfg_data_i,
  input logic [NUM_LUTS*LUT_K-1:0]     lut_in_i,
  input logic [NUM_LUTS-1:0]           o6_o,
  input logic [NUM_LUTS-1:0]           o5_1_o,
  input logic [NUM_LUTS-1:0]           o5_2_o,
  input logic [NUM_LUTS*FIELD_W-1:0]   cfg_chain
);
  localparam int unsigned CHAIN_W = NUM_LUTS * FIELD_W;

  // R2: shift behaviour of the chain
  p_cfg_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> (cfg_chain[CHAIN_W-1] == $past(cfg_data_i)) &&
                 (cfg_chain[CHAIN_W-2:0] == $past(cfg_chain[CHAIN_W-1:1])));

  // R10: configuration retained while shifting is off
  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(cfg_chain));

  // R1: empty configuration gives all-zero outputs
  p_empty_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_chain == '0) |-> (o6_o == '0) && (o5_1_o == '0) && (o5_2_o == '0));

  for (genvar i = 0; i < NUM_LUTS; i++) begin : g_chk
    // R3: six-input output follows the half chosen by A6
    p_o6_pick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_en_i |-> (o6_o[i] == (lut_in_i[i*LUT_K+5] ? o5_2_o[i] : o5_1_o[i])));

    // R6: lower half exposing its mux output, mux forced high
    p_const_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_en_i &&
       cfg_chain[i*FIELD_W +: HALF_W] == 32'hFFFF0000 &&
       cfg_chain[i*FIELD_W+TT_W +: SEL_W] == 2'b10) |-> o5_1_o[i]);
  end
endmodule

bind lut_slice lut_slice_checker #(.NUM_LUTS(NUM_LUTS)) u_lut_slice_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_en_i  (cfg_en_i),
  .cfg_data_i(cfg_data_i),
  .lut_in_i  (lut_in_i),
  .o6_o      (o6_o),
  .o5_1_o    (o5_1_o),
  .o5_2_o    (o5_2_o),
  .cfg_chain (cfg_chain)
);

// File: tb/lut_slice_bench.sv
module lut_slice_bench;
  localparam int NL = 8;
  localparam int FW = 68;
  localparam int CW = NL * FW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_en_i = 1'b0;
  logic          cfg_data_i = 1'b0;
  logic [NL*6-1:0] lut_in_i = '0;
  logic [NL-1:0] o6_o, o5_1_o, o5_2_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  lut_slice #(.NUM_LUTS(NL)) u_lut_slice (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_data_i(cfg_data_i),
    .lut_in_i(lut_in_i), .o6_o(o6_o), .o5_1_o(o5_1_o), .o5_2_o(o5_2_o)
  );

  typedef struct packed {
    logic [47:0] stim;
    logic [7:0]  e6;
    logic [7:0]  e51;
    logic [7:0]  e52;
  } vec_t;

  // config 1: lower = fifth input via cascade, upper = A1 with pin select
  // tables ordered {H,G,F,E,D,C,B,A}; bit 5 = A6, bit 4 = A5, bit 0 = A1
  localparam vec_t VECS [5] = '{
    '{{6'h00,6'h00,6'h00,6'h00,6'h00,6'h00,6'h00,6'h00}, 8'hFF, 8'hFF, 8'h00},
    '{{6'h00,6'h00,6'h00,6'h00,6'h00,6'h20,6'h00,6'h00}, 8'h03, 8'h07, 8'h00},
    '{{6'h00,6'h00,6'h00,6'h21,6'h00,6'h20,6'h00,6'h00}, 8'hF3, 8'hE7, 8'h10},
    '{{6'h3E,6'h3F,6'h3E,6'h3F,6'h3E,6'h3F,6'h3E,6'h3F}, 8'h55, 8'hAB, 8'h55},
    '{{6'h20,6'h00,6'h00,6'h00,6'h00,6'h00,6'h00,6'h00}, 8'h7F, 8'hFF, 8'h00}
  };

  function automatic logic [FW-1:0] fld(logic [1:0] sh, logic [1:0] sl,
                                       logic [31:0] th, logic [31:0] tl);
    return {sh, sl, th, tl};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(logic [CW-1:0] img);
    @(negedge clk_i);
    cfg_en_i = 1'b1;
    for (int k = 0; k < CW; k++) begin
      cfg_data_i = img[k];
      @(negedge clk_i);
    end
    cfg_en_i = 1'b0;
    cfg_data_i = 1'b0;
  endtask

  task automatic apply(logic [47:0] s);
    @(negedge clk_i);
    lut_in_i = s;
    #2;
  endtask

  task automatic chk3(string req, logic [7:0] e6, logic [7:0] e51, logic [7:0] e52);
    chk({req, " o6"}, o6_o, e6);
    chk({req, " o5_1"}, o5_1_o, e51);
    chk({req, " o5_2"}, o5_2_o, e52);
  endtask

  logic [CW-1:0] img;

  initial begin
    // R1 during and after reset, no configuration
    lut_in_i = {8{6'h3F}};
    #2;
    chk3("R1 in reset", 8'h00, 8'h00, 8'h00);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    apply({8{6'h2A}});
    chk3("R1 unconfigured", 8'h00, 8'h00, 8'h00);

    // config 1: R2 R3 R4 R7 R8 cascade ripple
    img = '0;
    for (int i = 0; i < NL; i++)
      img[i*FW +: FW] = fld(2'b00, 2'b01, 32'hAAAAAAAA, 32'hFFFF0000);
    load(img);
    foreach (VECS[v]) begin
      apply(VECS[v].stim);
      chk3($sformatf("R2 R3 R4 R7 R8 vec%0d", v), VECS[v].e6, VECS[v].e51, VECS[v].e52);
    end

    // config 2: A lower HIGH, B lower reserved, C lower cascade / upper pin
    img = '0;
    img[0*FW +: FW] = fld(2'b00, 2'b10, 32'hFFFF0000, 32'hFFFF0000);
    img[1*FW +: FW] = fld(2'b00, 2'b11, 32'hFFFF0000, 32'hFFFF0000);
    img[2*FW +: FW] = fld(2'b00, 2'b01, 32'hFFFF0000, 32'hFFFF0000);
    load(img);

    apply({5{6'h00}} << 18 | {6'h00, 6'h10, 6'h00});
    chk3("R5 R6 R9 cascade=1 pin=0", 8'h07, 8'h07, 8'h02);
    apply({30'h0, 6'h30, 6'h00, 6'h30});
    chk3("R5 R6 R9 cascade=0 pin=1", 8'h05, 8'h01, 8'h05);
    apply({30'h0, 6'h00, 6'h00, 6'h20});
    chk3("R3 R6 A6 picks upper", 8'h00, 8'h01, 8'h00);

    // R10: data toggling with shift disabled
    apply({30'h0, 6'h00, 6'h10, 6'h00});
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      cfg_data_i = ~cfg_data_i;
    end
    cfg_data_i = 1'b0;
    #2;
    chk3("R10 hold", 8'h07, 8'h07, 8'h02);

    // R1 asynchronous clear of a loaded configuration
    #1;
    rst_ni = 1'b0;
    #1;
    chk3("R1 async clear", 8'h00, 8'h00, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule